// File: doc/BRIEF.md
# Programmable Baud-Rate Clock Generator Bank

This block makes the baud-rate timing for serial controllers that sample each bit sixteen times. It has a small bank of identical generators. Each one divides the system clock by a programmable ratio. The ratio comes from a 12-bit reloadable down-counter, with an optional fixed divide-by-16 stage in front of it for slow rates. Each generator gives two outputs: a single-cycle enable pulse at the programmed rate, and a square-wave clock that changes level once per pulse.

Software sets up each generator by writing one configuration word. The write port picks the generator by its word index. The word holds an enable flag, a prescale flag, and a divisor stored as the wanted ratio minus one. Any write restarts that generator's prescaler and counter, so timing after the write is exact. A generator that is not enabled keeps its outputs idle.

Top module: `baud_gen_bank`

## Requirements
- R1: After reset every tick output is 0 and every generated clock output is 0.
- R2: The configuration word is 14 bits wide. Bit 0 selects the divide-by-16 prescaler, bits [12:1] hold the divisor D (ratio minus one), and bit 13 enables the generator. A write with `cfg_we` high goes to the generator whose index is on `cfg_sel`.
- R3: With the prescaler off and the generator enabled, the first tick is seen D+1 clock edges after the write edge. After that a tick comes every D+1 cycles.
- R4: With the prescaler on, the first tick comes 16*(D+1) edges after the write edge, and then one every 16*(D+1) cycles.
- R5: With D = 0 and the prescaler off, the tick output stays high on every cycle after the write edge.
- R6: The largest divisor, D = 4095, gives a tick interval of 4096 cycles.
- R7: While the enable bit is 0, the tick output stays 0 and the generated clock stays 0.
- R8: A write to a running generator restarts its prescaler and counter. The next tick is timed from the new write edge, not from the earlier one.
- R9: The generated clock inverts on the cycle after each tick, so its period is twice the tick interval.
- R10: A write to one generator does not change the timing of any other generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the source being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Index of the generator being written |
| cfg_wdata | input | 14 | Configuration word: enable, divisor, prescale flag |
| baud_tick | output | 4 | One-cycle rate pulse, one bit per generator |
| baud_clk | output | 4 | Square-wave clock, one bit per generator |

## Verification
The tick output is registered, so a write at edge E0 gives its first tick after edge E(D+1), or after E(16*(D+1)) when the prescaler is on. The generated clock changes one edge after that. The bench drives inputs at the falling edge and samples at each following falling edge. It counts samples from the write edge and compares the count with the closed-form interval from the requirements. For the restart and isolation cases, the bench counts the cycles spent on the intermediate writes, so the expected counts stay exact.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int DIV_W     = 12;
    localparam int PRE_RATIO = 16;
    localparam int NUM_GEN   = 4;
    localparam int CFG_W     = DIV_W + 2;

    // Layout of a configuration word: enable on top, divisor in the middle,
    // prescale select in bit 0.
    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic             pre;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{en: 1'b0, div: '0, pre: 1'b0};

    function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        return cfg_t'(w);
    endfunction

    typedef struct packed {
        logic tick;
        logic bclk;
    } gen_out_t;

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int RATIO = baud_gen_pkg::PRE_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic bypass,
    output logic adv
);
    localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] TOP = PW'(RATIO - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre_q <= TOP;
        end else if (pre_q == '0) begin
            pre_q <= TOP;
        end else begin
            pre_q <= pre_q - 1'b1;
        end
    end

    assign adv = run && (bypass || (pre_q == '0));

    // R4: after a prescaler wrap with no restart, the stage starts again from its top value
    a_r4_pre_wrap: assert property (@(posedge clk) disable iff (rst)
        (run && !restart && pre_q == '0) |=> (pre_q == TOP));

    // R7: a disabled stage is held at its reload value
    a_r7_pre_hold: assert property (@(posedge clk) disable iff (rst)
        (!run) |=> (pre_q == TOP));

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
    parameter int W = baud_gen_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         run,
    input  logic         adv,
    input  logic [W-1:0] reload,
    output logic         tick
);
    logic [W-1:0] cnt_q;
    logic         tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (restart || !run) begin
            cnt_q  <= reload;
            tick_q <= 1'b0;
        end else if (adv) begin
            if (cnt_q == '0) begin
                cnt_q  <= reload;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q - 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R3: the counter never holds a value above the loaded divisor
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (!restart && run) |-> (cnt_q <= reload));

    // R8: a restart suppresses a tick on the following cycle
    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        restart |=> !tick);

endmodule

// File: rtl/brg_channel.sv
module brg_channel
    import baud_gen_pkg::*;
#(
    parameter int PRE = PRE_RATIO
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output gen_out_t         out
);
    cfg_t cfg_q;
    cfg_t cfg_d;
    logic adv;
    logic tick;
    logic bclk_q;

    assign cfg_d = wr ? unpack_cfg(wdata) : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    brg_prescaler #(.RATIO(PRE)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr),
        .run     (cfg_q.en),
        .bypass  (!cfg_q.pre),
        .adv     (adv)
    );

    brg_divider #(.W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .restart (wr),
        .run     (cfg_q.en),
        .adv     (adv),
        .reload  (cfg_d.div),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || wr || !cfg_q.en) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk_q ^ tick;
        end
    end

    assign out.tick = tick;
    assign out.bclk = bclk_q;

    // R9: the generated clock inverts on the cycle after a tick
    a_r9_clk_toggle: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg_q.en && !wr) |=> (bclk_q != $past(bclk_q)));

    // R7: a disabled generator emits no tick and holds its clock low
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !wr) |=> (!out.tick && !out.bclk));

endmodule

// File: rtl/baud_gen_bank.sv
module baud_gen_bank
    import baud_gen_pkg::*;
#(
    parameter int N_GEN = NUM_GEN,
    parameter int PRE   = PRE_RATIO
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    cfg_we,
    input  logic [((N_GEN > 1) ? $clog2(N_GEN) : 1)-1:0] cfg_sel,
    input  logic [CFG_W-1:0]                        cfg_wdata,
    output logic [N_GEN-1:0]                        baud_tick,
    output logic [N_GEN-1:0]                        baud_clk
);
    localparam int SEL_W = (N_GEN > 1) ? $clog2(N_GEN) : 1;

    logic     [N_GEN-1:0] wr_vec;
    gen_out_t             gen_out [N_GEN];

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        assign wr_vec[g] = cfg_we && (cfg_sel == SEL_W'(g));

        brg_channel #(.PRE(PRE)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_vec[g]),
            .wdata (cfg_wdata),
            .out   (gen_out[g])
        );

        assign baud_tick[g] = gen_out[g].tick;
        assign baud_clk[g]  = gen_out[g].bclk;
    end

    // R10: a write strobe reaches at most one generator
    a_r10_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_vec));

    // R1: outputs are idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (baud_tick == '0 && baud_clk == '0));

endmodule

// File: tb/baud_gen_bank_tb_top.sv
module baud_gen_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [13:0] cfg_wdata;
    logic [3:0]  baud_tick;
    logic [3:0]  baud_clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    baud_gen_bank dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .baud_tick (baud_tick),
        .baud_clk  (baud_clk)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the write edge.
    task automatic do_write(input int ch, input bit en, input int d, input bit p);
        logic [11:0] dv;
        dv        = d[11:0];
        cfg_sel   = ch[1:0];
        cfg_wdata = {en, dv, p};
        cfg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Number of falling-edge samples until the tick of ch is high; -1 on timeout.
    task automatic wait_tick(input int ch, input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!baud_tick[ch] && n < limit);
        if (!baud_tick[ch]) n = -1;
    endtask

    task automatic t_reset;
        check("R1 tick", int'(baud_tick), 0);
        check("R1 clk", int'(baud_clk), 0);
    endtask

    task automatic t_basic;
        int n;
        do_write(0, 1'b1, 5, 1'b0);
        wait_tick(0, 100, n); check("R3/R2 first", n, 6);
        wait_tick(0, 100, n); check("R3 period", n, 6);
        wait_tick(0, 100, n); check("R3 period2", n, 6);
    endtask

    task automatic t_zero;
        int hi = 0;
        do_write(0, 1'b1, 0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (baud_tick[0]) hi++;
        end
        check("R5 every cycle", hi, 8);
    endtask

    task automatic t_pre;
        int n;
        do_write(1, 1'b1, 2, 1'b1);
        wait_tick(1, 200, n); check("R4/R2 first", n, 48);
        wait_tick(1, 200, n); check("R4 period", n, 48);
    endtask

    task automatic t_max;
        int n;
        do_write(2, 1'b1, 4095, 1'b0);
        wait_tick(2, 5000, n); check("R6 first", n, 4096);
        wait_tick(2, 5000, n); check("R6 period", n, 4096);
        do_write(2, 1'b0, 0, 1'b0);
    endtask

    task automatic t_disable;
        int seen = 0;
        do_write(0, 1'b0, 3, 1'b0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_tick[0] || baud_clk[0]) seen++;
        end
        check("R7 idle", seen, 0);
    endtask

    task automatic t_restart;
        int n;
        do_write(0, 1'b1, 9, 1'b0);
        repeat (4) @(negedge clk);
        do_write(0, 1'b1, 9, 1'b0);
        wait_tick(0, 100, n); check("R8 restart", n, 10);
    endtask

    task automatic t_toggle;
        int n;
        logic c0;
        do_write(3, 1'b1, 3, 1'b0);
        for (int k = 0; k < 2; k++) begin
            wait_tick(3, 100, n);
            c0 = baud_clk[3];
            @(negedge clk);
            check("R9 toggle", int'(baud_clk[3]), int'(!c0));
        end
        wait_tick(3, 100, n); check("R9 tick spacing", n, 3);
    endtask

    task automatic t_indep;
        int n;
        do_write(0, 1'b1, 7, 1'b0);
        repeat (3) @(negedge clk);
        do_write(1, 1'b1, 1, 1'b0);
        wait_tick(0, 100, n); check("R10 isolation", n, 4);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero();
        t_pre();
        t_max();
        t_disable();
        t_restart();
        t_toggle();
        t_indep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule